// File: doc/BRIEF.md
# Shared-Line I2C Clock Synchronizer

This block produces the clock pull-down for an I2C master whose SCL wire is shared with other masters through a wired-AND connection. It does not run a fixed divider. It times its own low period and high period in system clock cycles and watches the real level of the line. Another device can stretch a low phase. Another device can also cut a high phase short. In both cases the block restarts its timing from what it observes on the line.

Across all participants, the shared clock ends up with the longest low period and the shortest high period. The block reports its phase to the bit engine next to it:

- idle
- counting low
- waiting for the line to rise
- counting high

Data, arbitration and START/STOP sequencing belong to other blocks.

Top module: `scl_sync_gen`

## Requirements
- R1: While `rst_n` is low and afterwards until `enable` is set, `phase` reads 0 (idle) and `scl_pull` is 0 (line released). The phase code is 0 idle, 1 low count, 2 high wait, 3 high count.
- R2: From idle, a sampled `enable` of 1 moves `phase` to 2 (high wait) on the next clock, with `scl_pull` still 0.
- R3: In phase 1 the block keeps `scl_pull` at 1 for exactly the effective low count of cycles. It then releases the line and enters phase 2.
- R4: In phase 2 the block keeps `scl_pull` at 0 and stays in phase 2 for as long as `scl_in` reads 0, however long another device holds the line.
- R5: When `scl_in` reads 1 in phase 2, the block enters phase 3 on the next clock, with a fresh high count.
- R6: Phase 3 lasts exactly the effective high count of cycles and then enters phase 1 (pull-down). With no other device on the line, the line therefore stays high for the high count plus one cycle.
- R7: A 1-to-0 change of `scl_in` during phase 3 cuts the high count short. Phase 1 starts on the next clock with a full, restarted low count.
- R8: A sampled `enable` of 0 sends any phase to idle on the next clock with `scl_pull` 0. While disabled, activity on `scl_in` is ignored.
- R9: The effective count is the programmed count, except that a programmed `low_count` or `high_count` below 2 counts as 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the clock generator; 0 forces idle |
| scl_in | input | 1 | Observed SCL level (already sampled by default) |
| low_count | input | 8 | Own low period in clock cycles (minimum 2) |
| high_count | input | 8 | Own high period in clock cycles (minimum 2) |
| scl_pull | output | 1 | 1 drives the shared SCL line low |
| phase | output | 2 | Current phase: 0 idle, 1 low, 2 high wait, 3 high |

## Verification
A wrong internal phase always shows up at the ports within one clock, because `scl_pull` and `phase` come straight from the state register. The failure looks like a pull-down while another device holds the line, or a missing pull-down after a high count. A counter that restarts late or saturates wrongly shows up within one line period, as low or high times that differ from the programmed counts. An override from another device that is not honoured shows up on the next clock after the line changes: a stretched low phase leaves phase 2 too early, or a cut-short high phase keeps counting.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LOW   = 2'd1,
      PH_WAIT  = 2'd2,
      PH_HIGH  = 2'd3
   } scl_phase_e;

   function automatic logic [7:0] clamp_period(input logic [7:0] raw, input logic [7:0] floor_v);
      return (raw < floor_v) ? floor_v : raw;
   endfunction

endpackage

// File: rtl/scl_line_sampler.sv
module scl_line_sampler #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_now,
   output logic line_fell,
   output logic line_rose
);

   initial begin
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4)
         $error("scl_line_sampler: SYNC_STAGES must be 0..4");
   end

   logic line_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign line_now = line_raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], line_raw};
         end
         assign line_now = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_prev <= 1'b1;
      else        line_prev <= line_now;
   end

   assign line_fell = line_prev & ~line_now;
   assign line_rose = ~line_prev & line_now;

endmodule

// File: rtl/scl_period_timer.sv
module scl_period_timer #(
   parameter int CNT_W      = 8,
   parameter int MIN_PERIOD = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);

   localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_PERIOD);

   initial begin
      if (CNT_W < 2) $error("scl_period_timer: CNT_W must be at least 2");
      if (MIN_PERIOD < 1 || MIN_PERIOD >= (1 << CNT_W))
         $error("scl_period_timer: MIN_PERIOD out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] eff_limit;

   assign eff_limit = (limit < FLOOR) ? FLOOR : limit;
   assign expired   = run && (cnt_q == eff_limit - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (run)     cnt_q <= cnt_q + CNT_W'(1);
   end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
   import scl_sync_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       line_now,
   input  logic       line_fell,
   input  logic       expired,
   output scl_phase_e phase_q,
   output logic       restart,
   output logic       run
);

   scl_phase_e phase_d;

   always_comb begin
      phase_d = phase_q;
      if (!enable) begin
         phase_d = PH_IDLE;
      end else begin
         case (phase_q)
            PH_IDLE: phase_d = PH_WAIT;
            PH_WAIT: if (line_now) phase_d = PH_HIGH;
            PH_HIGH: if (expired || line_fell) phase_d = PH_LOW;
            PH_LOW:  if (expired) phase_d = PH_WAIT;
            default: phase_d = PH_IDLE;
         endcase
      end
   end

   assign restart = (phase_d != phase_q);
   assign run     = (phase_q == PH_LOW) || (phase_q == PH_HIGH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen
   import scl_sync_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int MIN_PERIOD  = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             scl_in,
   input  logic [CNT_W-1:0] low_count,
   input  logic [CNT_W-1:0] high_count,
   output logic             scl_pull,
   output logic [1:0]       phase
);

   logic       line_now, line_fell, line_rose;
   logic       expired, restart, run;
   scl_phase_e phase_q;
   logic [CNT_W-1:0] active_limit;

   scl_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .line_raw(scl_in),
      .line_now(line_now), .line_fell(line_fell), .line_rose(line_rose)
   );

   assign active_limit = (phase_q == PH_LOW) ? low_count : high_count;

   scl_period_timer #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(restart), .run(run),
      .limit(active_limit), .expired(expired)
   );

   scl_phase_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .line_now(line_now), .line_fell(line_fell), .expired(expired),
      .phase_q(phase_q), .restart(restart), .run(run)
   );

   logic unused_rose;
   assign unused_rose = line_rose;

   assign scl_pull = (phase_q == PH_LOW);
   assign phase    = phase_q;

endmodule

// File: rtl/scl_sync_gen_chk.sv
module scl_sync_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic       scl_in,
   input logic       scl_pull,
   input logic [1:0] phase
);

   logic [15:0] pull_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pull_run <= '0;
      else if (scl_pull) pull_run <= pull_run + 16'd1;
      else               pull_run <= '0;
   end

   AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!scl_pull && phase == 2'd0)); // R8

   AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && phase == 2'd2 && !scl_in) |=> (phase == 2'd2 && !scl_pull)); // R4

   AST_WAIT_TO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && phase == 2'd2 && scl_in) |=> phase == 2'd3); // R5

   AST_HIGH_CUT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && phase == 2'd3 && $past(scl_in) && !scl_in) |=> phase == 2'd1); // R7

   AST_IDLE_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && phase == 2'd0) |=> phase == 2'd2); // R2

   AST_PULL_MIN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_pull) && $past(enable)) |-> pull_run >= 16'd2); // R9

endmodule

bind scl_sync_gen scl_sync_gen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in),
   .scl_pull(scl_pull), .phase(phase)
);

// File: tb/scl_sync_gen_bench.sv
`timescale 1ns/1ps
module scl_sync_gen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       other_pull = 1'b0;
   logic [7:0] low_count = 8'd4;
   logic [7:0] high_count = 8'd4;
   logic       scl_pull;
   logic [1:0] phase;
   logic       bus;

   int errors = 0;
   int checks = 0;
   bit done_flag = 0;

   assign bus = ~(scl_pull | other_pull);

   always #2 clk = ~clk;

   scl_sync_gen u_scl_sync_gen (
      .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(bus),
      .low_count(low_count), .high_count(high_count),
      .scl_pull(scl_pull), .phase(phase)
   );

   localparam int NV = 6;
   localparam logic [7:0] TBL_L [NV] = '{8'd2, 8'd5, 8'd0, 8'd1, 8'd9, 8'd3};
   localparam logic [7:0] TBL_H [NV] = '{8'd2, 8'd3, 8'd4, 8'd1, 8'd6, 8'd12};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic measure(output int lo, output int hi);
      logic prev;
      prev = bus;
      forever begin
         @(negedge clk);
         if (prev && !bus) break;
         prev = bus;
      end
      lo = 1;
      forever begin
         @(negedge clk);
         if (!bus) lo++; else break;
      end
      hi = 1;
      forever begin
         @(negedge clk);
         if (bus) hi++; else break;
      end
   endtask

   function automatic int eff(input logic [7:0] v);
      return (v < 8'd2) ? 2 : int'(v);
   endfunction

   initial begin
      int lo, hi;
      repeat (3) @(negedge clk);
      check(phase == 2'd0 && scl_pull == 1'b0, "R1 reset idle", int'(phase), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(phase == 2'd0 && scl_pull == 1'b0, "R1 idle after reset", int'(phase), 0);

      enable = 1'b1;
      @(negedge clk);
      check(phase == 2'd2 && scl_pull == 1'b0, "R2 enable to wait", int'(phase), 2);

      for (int i = 0; i < NV; i++) begin
         low_count  = TBL_L[i];
         high_count = TBL_H[i];
         measure(lo, hi);
         measure(lo, hi);
         check(lo == eff(TBL_L[i]), "R3/R9 low time", lo, eff(TBL_L[i]));
         check(hi == eff(TBL_H[i]) + 1, "R6/R9 high time", hi, eff(TBL_H[i]) + 1);
      end

      low_count = 8'd5;
      high_count = 8'd20;
      while (phase != 2'd1) @(negedge clk);
      other_pull = 1'b1;
      repeat (8) @(negedge clk);
      check(phase == 2'd2 && scl_pull == 1'b0, "R4 stretched low waits", int'(phase), 2);
      repeat (30) @(negedge clk);
      check(phase == 2'd2 && scl_pull == 1'b0, "R4 long stretch waits", int'(phase), 2);
      other_pull = 1'b0;
      @(negedge clk);
      check(phase == 2'd3, "R5 line high starts high count", int'(phase), 3);

      repeat (3) @(negedge clk);
      other_pull = 1'b1;
      @(negedge clk);
      other_pull = 1'b0;
      check(phase == 2'd1 && scl_pull == 1'b1, "R7 high cut short", int'(phase), 1);
      repeat (4) @(negedge clk);
      check(scl_pull == 1'b1, "R7 full low restarted", int'(scl_pull), 1);
      @(negedge clk);
      check(scl_pull == 1'b0 && phase == 2'd2, "R7 low ends after count", int'(phase), 2);

      while (phase != 2'd3) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      check(phase == 2'd0 && scl_pull == 1'b0, "R8 disable to idle", int'(phase), 0);
      for (int k = 0; k < 6; k++) begin
         other_pull = ~other_pull;
         @(negedge clk);
      end
      other_pull = 1'b0;
      check(phase == 2'd0 && scl_pull == 1'b0, "R8 bus ignored while disabled", int'(phase), 0);

      enable = 1'b1;
      other_pull = 1'b1;
      repeat (5) @(negedge clk);
      check(phase == 2'd2 && scl_pull == 1'b0, "R2 start waits on held line", int'(phase), 2);
      other_pull = 1'b0;
      @(negedge clk);
      check(phase == 2'd3, "R5 start high count", int'(phase), 3);

      done_flag = 1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done_flag && cyc < 100000) begin
         @(negedge clk);
         cyc++;
      end
      if (!done_flag) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule